// File: doc/BRIEF.md
# Double-Rate Burst-of-Two SRAM Read Pipeline

A small synchronous memory whose read port returns each access as a pair of words on consecutive half-cycle edges. A command is taken on a rising edge of the input clock. Load strobe low with read/write high starts a read. Load strobe low with read/write low starts a write. The captured address is held in a register. Its least significant bit sets where a two-word linear burst starts, and the burst wraps inside the aligned pair. A mode pin chooses between a full latency of one and a half input cycles and a reduced latency of one input cycle.

The design is synthesizable and runs from a single clock, `fclk`, at twice the input-clock rate. An internal phase flag marks which `fclk` edges are rising edges of the input clock. After reset, the first `fclk` edge with `rst` low is an input-clock edge, and every second edge after it is one too. Latencies below are counted in `fclk` edges. Edge 0 is the input-clock edge that captures the command.

Top module: `ddrb_sram`

## Requirements
- R1: While `rst` is high, and after it is released, `rvalid` is 0 and `rdata` is 0 until a read produces data.
- R2: A read starts only when `load_n` is 0 and `rnw` is 1 on an input-clock edge. With `load_n` at 1, neither a read nor a write takes place.
- R3: A read returns two words: first the word at the captured address, then the word at that address with bit 0 inverted. A start with bit 0 equal to 1 therefore returns word 1 and then word 0 of the pair.
- R4: With `full_lat` = 1 at the command edge, the first word appears on `rdata` after `fclk` edge 3 and the second after edge 4.
- R5: With `full_lat` = 0 at the command edge, the first word appears after `fclk` edge 2 and the second after edge 3.
- R6: `rvalid` is 1 for exactly the two `fclk` cycles of each burst. `rdata` is 0 whenever `rvalid` is 0.
- R7: On the input-clock edge right after an accepted command, any command is ignored: no read burst starts and no write occurs. The edge after that accepts commands again.
- R8: A write takes `wdata` at edge 0 into the captured address and `wdata` at edge 1 into that address with bit 0 inverted.
- R9: Address, mode and data are sampled at their capture edges. Later changes to these pins do not affect the command in flight.
- R10: A synchronous reset in the middle of a burst cancels the rest of it, so `rvalid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fclk | input | 1 | Clock at twice the input-clock rate |
| rst | input | 1 | Synchronous reset, active high |
| load_n | input | 1 | Command strobe, active low |
| rnw | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Word address |
| full_lat | input | 1 | 1 = 1.5-cycle latency, 0 = 1-cycle latency |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, 0 when idle |
| rvalid | output | 1 | High during the two beats of a burst |

## Verification
The bench targets four cases:
- **Odd start address.** A design that counted the burst up without wrapping would return the neighbouring pair's word as the second beat.
- **Each latency mode, including mode changes right after the command.** A design that read the pin instead of its registered copy would shift the beats by one edge.
- **A command on the edge just after an accepted one.** A design without the spacing rule would start an extra burst or overwrite a stored pair.
- **Reset in the middle of a burst.** A design that left the burst state alone would emit a stray beat after reset.

// File: rtl/ddrb_pkg.sv
package ddrb_pkg;

  localparam int FULL_LAT_EDGES    = 3;
  localparam int REDUCED_LAT_EDGES = 2;

  typedef enum logic [1:0] {
    BS_IDLE = 2'd0,
    BS_WAIT = 2'd1,
    BS_ARM  = 2'd2,
    BS_LAST = 2'd3
  } burst_st_t;

  // bit 0 of the word fetched on a beat: linear count wrapping in the pair
  function automatic logic beat_lsb(input logic start_lsb, input logic beat);
    return start_lsb ^ beat;
  endfunction

  // state entered one edge after the command: full latency adds a wait edge
  function automatic burst_st_t entry_state(input logic full_mode);
    return full_mode ? BS_WAIT : BS_ARM;
  endfunction

endpackage

// File: rtl/ddrb_phase.sv
module ddrb_phase (
  input  logic fclk,
  input  logic rst,
  output logic in_edge
);
  logic ph;

  always_ff @(posedge fclk) begin
    if (rst) ph <= 1'b0;
    else     ph <= ~ph;
  end

  assign in_edge = ~ph;
endmodule

// File: rtl/ddrb_cmd.sv
module ddrb_cmd #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 18
) (
  input  logic              fclk,
  input  logic              rst,
  input  logic              in_edge,
  input  logic              load_n,
  input  logic              rnw,
  input  logic [ADDR_W-1:0] addr,
  input  logic              full_lat,
  input  logic [DATA_W-1:0] wdata,
  output logic              accept,
  output logic              rd_go,
  output logic              wr_commit,
  output logic [ADDR_W-1:0] addr_q,
  output logic              mode_q,
  output logic [DATA_W-1:0] wd0,
  output logic [DATA_W-1:0] wd1
);
  logic busy;
  logic wr_s1;

  assign accept = in_edge & ~load_n & ~busy;

  always_ff @(posedge fclk) begin
    if (rst) begin
      busy      <= 1'b0;
      rd_go     <= 1'b0;
      wr_s1     <= 1'b0;
      wr_commit <= 1'b0;
      addr_q    <= '0;
      mode_q    <= 1'b0;
      wd0       <= '0;
      wd1       <= '0;
    end else begin
      rd_go     <= accept & rnw;
      wr_s1     <= accept & ~rnw;
      wr_commit <= wr_s1;
      if (in_edge) busy <= accept;
      if (accept) begin
        addr_q <= addr;
        mode_q <= full_lat;
        wd0    <= wdata;
      end
      if (wr_s1) wd1 <= wdata;
    end
  end

  AST_ACCEPT_SPACING: assert property (@(posedge fclk) disable iff (rst)
    accept |=> !accept ##1 !accept); // R7
endmodule

// File: rtl/ddrb_burst.sv
module ddrb_burst
  import ddrb_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              fclk,
  input  logic              rst,
  input  logic              rd_go,
  input  logic              mode_q,
  input  logic [ADDR_W-1:0] addr_q,
  output logic              emit,
  output logic              busy_o,
  output logic [ADDR_W-1:0] rd_addr
);
  burst_st_t st;

  always_ff @(posedge fclk) begin
    if (rst) st <= BS_IDLE;
    else begin
      unique case (st)
        BS_IDLE: if (rd_go) st <= entry_state(mode_q);
        BS_WAIT: st <= BS_ARM;
        BS_ARM:  st <= BS_LAST;
        BS_LAST: st <= BS_IDLE;
        default: st <= BS_IDLE;
      endcase
    end
  end

  assign emit    = (st == BS_ARM) || (st == BS_LAST);
  assign busy_o  = (st != BS_IDLE);
  assign rd_addr = {addr_q[ADDR_W-1:1], beat_lsb(addr_q[0], st == BS_LAST)};

  AST_LAST_FOLLOWS_ARM: assert property (@(posedge fclk) disable iff (rst)
    (st == BS_ARM) |=> (st == BS_LAST)); // R6
endmodule

// File: rtl/ddrb_array.sv
module ddrb_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 18
) (
  input  logic              fclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wbase,
  input  logic [DATA_W-1:0] wd0,
  input  logic [DATA_W-1:0] wd1,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rword
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] waddr_b;

  assign waddr_b = {wbase[ADDR_W-1:1], ~wbase[0]};

  always_ff @(posedge fclk) begin
    if (we) begin
      mem[wbase]   <= wd0;
      mem[waddr_b] <= wd1;
    end
  end

  assign rword = mem[raddr];
endmodule

// File: rtl/ddrb_sram.sv
module ddrb_sram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 18
) (
  input  logic              fclk,
  input  logic              rst,
  input  logic              load_n,
  input  logic              rnw,
  input  logic [ADDR_W-1:0] addr,
  input  logic              full_lat,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic              in_edge, accept, rd_go, wr_commit, mode_q;
  logic              emit, burst_busy;
  logic [ADDR_W-1:0] addr_q, rd_addr;
  logic [DATA_W-1:0] wd0, wd1, rword;

  ddrb_phase u_phase (.fclk(fclk), .rst(rst), .in_edge(in_edge));

  ddrb_cmd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
    .fclk(fclk), .rst(rst), .in_edge(in_edge), .load_n(load_n), .rnw(rnw),
    .addr(addr), .full_lat(full_lat), .wdata(wdata), .accept(accept),
    .rd_go(rd_go), .wr_commit(wr_commit), .addr_q(addr_q), .mode_q(mode_q),
    .wd0(wd0), .wd1(wd1));

  ddrb_burst #(.ADDR_W(ADDR_W)) u_burst (
    .fclk(fclk), .rst(rst), .rd_go(rd_go), .mode_q(mode_q), .addr_q(addr_q),
    .emit(emit), .busy_o(burst_busy), .rd_addr(rd_addr));

  ddrb_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .fclk(fclk), .we(wr_commit), .wbase(addr_q), .wd0(wd0), .wd1(wd1),
    .raddr(rd_addr), .rword(rword));

  always_ff @(posedge fclk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else if (emit) begin
      rdata  <= rword;
      rvalid <= 1'b1;
    end else begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end
  end

  AST_NO_RESTART: assert property (@(posedge fclk) disable iff (rst)
    rd_go |-> !burst_busy); // R7
  AST_WRITE_QUIET: assert property (@(posedge fclk) disable iff (rst)
    wr_commit |-> !burst_busy); // R8
  AST_VALID_PAIR: assert property (@(posedge fclk) disable iff (rst)
    $rose(rvalid) |=> rvalid); // R6
  AST_VALID_MAX_TWO: assert property (@(posedge fclk) disable iff (rst)
    (rvalid && $past(rvalid)) |=> !rvalid); // R6
  AST_IDLE_ZERO: assert property (@(posedge fclk) disable iff (rst)
    !rvalid |-> (rdata == '0)); // R6
  AST_LAT_FULL: assert property (@(posedge fclk) disable iff (rst)
    ($rose(rvalid) && mode_q) |-> $past(rd_go, 3)); // R4
  AST_LAT_REDUCED: assert property (@(posedge fclk) disable iff (rst)
    ($rose(rvalid) && !mode_q) |-> $past(rd_go, 2)); // R5
endmodule

// File: tb/ddrb_sram_test.sv
`timescale 1ns/1ps
module ddrb_sram_test;
  logic        fclk = 1'b0;
  logic        rst = 1'b1;
  logic        load_n = 1'b1;
  logic        rnw = 1'b0;
  logic [5:0]  addr = '0;
  logic        full_lat = 1'b1;
  logic [17:0] wdata = '0;
  logic [17:0] rdata;
  logic        rvalid;

  ddrb_sram #(.ADDR_W(6), .DATA_W(18)) uut (
    .fclk(fclk), .rst(rst), .load_n(load_n), .rnw(rnw), .addr(addr),
    .full_lat(full_lat), .wdata(wdata), .rdata(rdata), .rvalid(rvalid));

  always #2.5 fclk = ~fclk;

  typedef struct { int cyc; int data; string req; } exp_t;
  exp_t sbq[$];
  logic [17:0] mm [64];
  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  int last_acc = -10;
  bit done = 0;

  always @(posedge fclk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  function automatic void chk(bit ok, string req, string what, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, expv, cyc);
    end
  endfunction

  // monitor: pops expected beats as the design produces them
  always @(negedge fclk) begin
    if (!rst) begin
      while (sbq.size() > 0 && sbq[0].cyc < cyc) begin
        chk(0, sbq[0].req, "missing beat at cycle", 0, sbq[0].cyc);
        void'(sbq.pop_front());
      end
      if (rvalid) begin
        if (sbq.size() == 0) chk(0, "R7", "unexpected beat", int'(rdata), 0);
        else begin
          exp_t e;
          e = sbq.pop_front();
          chk(e.cyc == cyc, e.req, "beat cycle", cyc, e.cyc);
          chk(rdata == e.data[17:0], e.req, "beat data", int'(rdata), e.data);
        end
      end else if (rdata != '0) begin
        chk(0, "R6", "idle data not zero", int'(rdata), 0);
      end
    end
  end

  task automatic idle(input int k);
    repeat (k) @(negedge fclk);
  endtask

  // driver: one command on the next input-clock edge; returns at negedge after edge 1
  task automatic cmd(input bit ld, input bit rd, input logic [5:0] a, input bit fm,
                     input logic [17:0] d0, input logic [17:0] d1, input bit track);
    int  n;
    bit  acc;
    int  lat;
    if (cyc % 2 != 0) @(negedge fclk);
    n   = cyc + 1;
    acc = !ld && (n != last_acc + 2);
    if (acc) last_acc = n;
    load_n = ld; rnw = rd; addr = a; full_lat = fm; wdata = d0;
    @(negedge fclk);
    load_n = 1'b1; addr = ~a; full_lat = ~fm; wdata = d1; // R9: pins move after capture
    @(negedge fclk);
    wdata = ~d1;
    if (acc && !rd) begin
      mm[a] = d0;
      mm[{a[5:1], ~a[0]}] = d1;
    end
    if (acc && rd && track) begin
      lat = fm ? 3 : 2;
      sbq.push_back('{n + lat,     int'(mm[a]),              fm ? "R3/R4/R9" : "R3/R5/R9"});
      sbq.push_back('{n + lat + 1, int'(mm[{a[5:1], ~a[0]}]), fm ? "R3/R4" : "R3/R5"});
    end
  endtask

  initial begin
    repeat (200000) @(posedge fclk);
    if (!done) begin
      chk(0, "ALL", "watchdog expired", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge fclk);
    chk(rvalid == 1'b0 && rdata == '0, "R1", "outputs in reset", int'(rdata), 0);
    rst = 1'b0;
    idle(1);
    chk(rvalid == 1'b0 && rdata == '0, "R1", "outputs after reset", int'(rdata), 0);

    // R8: writes, even and odd start
    cmd(0, 0, 6'd0,  1, 18'h0A001, 18'h0B002, 1); idle(2);
    cmd(0, 0, 6'd5,  1, 18'h1C005, 18'h1D004, 1); idle(2);
    cmd(0, 0, 6'd10, 0, 18'h2E010, 18'h2F011, 1); idle(2);
    cmd(0, 0, 6'd63, 1, 18'h3FFFF, 18'h30000, 1); idle(4);

    // R3/R4/R5: reads in both modes, both start parities
    cmd(0, 1, 6'd0,  1, 0, 0, 1); idle(4);
    cmd(0, 1, 6'd1,  1, 0, 0, 1); idle(4);
    cmd(0, 1, 6'd4,  0, 0, 0, 1); idle(4);
    cmd(0, 1, 6'd5,  0, 0, 0, 1); idle(4);
    cmd(0, 1, 6'd62, 1, 0, 0, 1); idle(4);
    cmd(0, 1, 6'd11, 0, 0, 0, 1); idle(4);

    // R7: read on the edge right after an accepted read is ignored
    cmd(0, 1, 6'd10, 1, 0, 0, 1);
    cmd(0, 1, 6'd0,  1, 0, 0, 1);
    cmd(0, 1, 6'd4,  0, 0, 0, 1); idle(6);

    // R7: write on the busy edge is ignored, old data remains
    cmd(0, 1, 6'd0,  0, 0, 0, 1);
    cmd(0, 0, 6'd0,  1, 18'h12345, 18'h23456, 1); idle(4);
    cmd(0, 1, 6'd0,  1, 0, 0, 1); idle(4);

    // R2: load_n high starts nothing, neither read nor write
    cmd(1, 1, 6'd4,  1, 0, 0, 1); idle(2);
    cmd(1, 0, 6'd4,  1, 18'h0DEAD, 18'h0BEEF, 1); idle(4);
    chk(sbq.size() == 0, "R2", "queued beats after idle strobes", sbq.size(), 0);
    cmd(0, 1, 6'd4,  1, 0, 0, 1); idle(6);

    // R10: reset in mid-burst cancels the remaining beats
    cmd(0, 1, 6'd0, 1, 0, 0, 0);
    rst = 1'b1;
    @(negedge fclk);
    rst = 1'b0;
    last_acc = -10;
    for (int i = 0; i < 6; i++) begin
      chk(rvalid == 1'b0, "R10", "valid after mid-burst reset", int'(rvalid), 0);
      @(negedge fclk);
    end

    // after reset the array still answers through normal reads
    cmd(0, 1, 6'd10, 0, 0, 0, 1); idle(8);
    chk(sbq.size() == 0, "R6", "beats left in scoreboard", sbq.size(), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule